// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Cache Controller

This block manages a small direct-mapped, write-through cache with one word per line and keeps it coherent with other caches on a shared bus. Each line holds a tag, a data word and one state bit, Valid or Invalid. Processor reads that hit are served locally. Every processor write, and every read that misses, becomes one atomic bus transaction: a read fetches a word and a write sends the word through to memory.

The controller also watches the bus for transactions from other caches. A write by another cache to a line held here invalidates that line. Reads by other caches have no effect. A build-time parameter chooses whether a write to an Invalid line installs it (write-allocate) or leaves it Invalid (write-no-allocate).

The processor pulses `cpu_req` for one cycle and then waits for `cpu_done`. The bus side raises `bus_req` and holds it until `bus_gnt`, drives the transaction for one cycle, then waits for `bus_ack`. Read data arrives with the acknowledge.

Top module: `wt_vi_snoop`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `bus_out_valid` and `cpu_done` are 0.
- R2: A read that matches the tag of a Valid line raises `cpu_done` in the cycle after the request, with the cached word on `cpu_rdata`, and no bus transaction.
- R3: A read that misses, or finds its line Invalid, issues one read transaction (`bus_out_write`=0). It completes with the `bus_rdata` word from the acknowledge cycle and leaves the line Valid, so the next read of that address hits.
- R4: A write to a Valid line with a matching tag issues one write transaction carrying the address and data. The line stays Valid and holds the new word.
- R5: With WRITE_ALLOC=1, a write to an Invalid or non-matching line issues one write transaction and installs the line as Valid with the written word.
- R6: With WRITE_ALLOC=0, such a write issues one write transaction and leaves the line as it was, so a later read of that address misses.
- R7: A snooped write (`snp_valid`=1, `snp_write`=1) whose address matches a Valid line makes that line Invalid.
- R8: A snooped read (`snp_write`=0), or a snooped write whose tag does not match the stored tag, leaves every line unchanged.
- R9: `bus_req` stays high until `bus_gnt` arrives. Each grant is followed in the next cycle by exactly one cycle of `bus_out_valid`. The request completes in the cycle after `bus_ack`.
- R10: When a snooped write to an address arrives in the same cycle as the local install of that address, the line ends Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle processor request pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data (write data on a write) |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus granted |
| bus_out_valid | output | 1 | Transaction driven this cycle |
| bus_out_write | output | 1 | 1 = write transaction, 0 = read |
| bus_out_addr | output | ADDR_W | Transaction address |
| bus_out_data | output | DATA_W | Transaction write data |
| bus_ack | input | 1 | Transaction acknowledged |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_write | input | 1 | That transaction is a write |
| snp_addr | input | ADDR_W | Its address |

## Verification
The assertions assume the processor pulses `cpu_req` only while no request is outstanding. They assume `bus_gnt` comes only in answer to `bus_req`, and `bus_ack` only in the cycle after a driven transaction. They also assume the snoop inputs never show this cache's own transaction. The bench bus model grants after a chosen delay and acknowledges exactly one cycle after `bus_out_valid`. The processor driver waits for `cpu_done` before issuing the next request. Snoops are injected only between requests, except in the one case that deliberately lines a snooped write up with the acknowledge cycle.

// File: rtl/wt_vi_snoop.sv
module wt_vi_snoop #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int IDX_W       = 2,
  parameter int WRITE_ALLOC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic              bus_out_write,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DRIVE, S_WAIT} st_t;

  st_t               st;
  logic              p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic [LINES-1:0]  valid;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] p_idx = p_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire rd_hit = valid[c_idx] && (tag_q[c_idx] == c_tag);
  wire p_hit  = valid[p_idx] && (tag_q[p_idx] == p_tag);
  wire upd    = (st == S_WAIT) && bus_ack;
  wire inst   = upd && (!p_we || p_hit || (WRITE_ALLOC != 0));
  wire s_kill = snp_valid && snp_write &&
                ((valid[s_idx] && (tag_q[s_idx] == s_tag)) ||
                 (inst && (p_idx == s_idx) && (p_tag == s_tag)));

  assign bus_req       = (st == S_REQ);
  assign bus_out_valid = (st == S_DRIVE);
  assign bus_out_write = p_we;
  assign bus_out_addr  = p_addr;
  assign bus_out_data  = p_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      p_we      <= 1'b0;
      p_addr    <= '0;
      p_wdata   <= '0;
      valid     <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          p_we    <= cpu_we;
          p_addr  <= cpu_addr;
          p_wdata <= cpu_wdata;
          if (!cpu_we && rd_hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= data_q[c_idx];
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ:   if (bus_gnt) st <= S_DRIVE;
        S_DRIVE: st <= S_WAIT;
        S_WAIT: if (bus_ack) begin
          st        <= S_IDLE;
          cpu_done  <= 1'b1;
          cpu_rdata <= p_we ? p_wdata : bus_rdata;
        end
        default: st <= S_IDLE;
      endcase
      if (inst) begin
        valid[p_idx]  <= 1'b1;
        tag_q[p_idx]  <= p_tag;
        data_q[p_idx] <= p_we ? p_wdata : bus_rdata;
      end
      if (s_kill) valid[s_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/wt_vi_snoop_chk.sv
module wt_vi_snoop_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_out_valid,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic              snp_write,
  input logic [ADDR_W-1:0] snp_addr,
  input logic [(1<<IDX_W)-1:0] valid,
  input logic [ADDR_W-IDX_W-1:0] tags [1<<IDX_W],
  input logic [1:0]        st
);
  localparam logic [1:0] WAIT_ST = 2'd3;
  wire [IDX_W-1:0]        sidx = snp_addr[IDX_W-1:0];
  wire [ADDR_W-IDX_W-1:0] stag = snp_addr[ADDR_W-1:IDX_W];

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  assert_drive_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |=> !bus_out_valid);
  assert_drive_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_out_valid) |-> $past(bus_req && bus_gnt));
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> ($past(cpu_req) || $past(bus_ack)));
  assert_snoop_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_write && valid[sidx] && (tags[sidx] == stag)
    |=> !valid[$past(sidx)]);
  assert_snoop_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_write && !((st == WAIT_ST) && bus_ack) |=> $stable(valid));
endmodule

bind wt_vi_snoop wt_vi_snoop_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid),
  .bus_ack(bus_ack), .snp_valid(snp_valid), .snp_write(snp_write),
  .snp_addr(snp_addr), .valid(valid), .tags(tag_q), .st(st)
);

// File: tb/wt_vi_snoop_tb.sv
module wt_vi_snoop_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit ended = 0;

  function automatic logic [15:0] memv(input logic [7:0] a);
    return {a ^ 8'hA5, a};
  endfunction

  logic [15:0] mem [256];
  logic        cpu_we = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        tb_sv = 0, tb_sw = 0;
  logic [7:0]  tb_sa = 0;
  logic        r_sv = 0;
  logic [7:0]  r_sa = 0;
  wire         snp_v = tb_sv | r_sv;
  wire         snp_w = r_sv ? 1'b1 : tb_sw;
  wire [7:0]   snp_a = r_sv ? r_sa : tb_sa;
  int          gnt_delay = 0;
  bit          snoop_on_ack = 0;

  logic a_req = 0, a_gnt = 0, a_ack = 0, a_done, a_breq, a_bov, a_bwr;
  logic [15:0] a_rd, a_bdata, a_brd = 0;
  logic [7:0]  a_baddr;
  logic n_req = 0, n_gnt = 0, n_ack = 0, n_done, n_breq, n_bov, n_bwr;
  logic [15:0] n_rd, n_bdata, n_brd = 0;
  logic [7:0]  n_baddr;

  wt_vi_snoop #(.WRITE_ALLOC(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(a_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(a_rd), .cpu_done(a_done), .bus_req(a_breq),
    .bus_gnt(a_gnt), .bus_out_valid(a_bov), .bus_out_write(a_bwr), .bus_out_addr(a_baddr),
    .bus_out_data(a_bdata), .bus_ack(a_ack), .bus_rdata(a_brd),
    .snp_valid(snp_v), .snp_write(snp_w), .snp_addr(snp_a));

  wt_vi_snoop #(.WRITE_ALLOC(0)) u_dut_na (
    .clk(clk), .rst_n(rst_n), .cpu_req(n_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(n_rd), .cpu_done(n_done), .bus_req(n_breq),
    .bus_gnt(n_gnt), .bus_out_valid(n_bov), .bus_out_write(n_bwr), .bus_out_addr(n_baddr),
    .bus_out_data(n_bdata), .bus_ack(n_ack), .bus_rdata(n_brd),
    .snp_valid(snp_v), .snp_write(snp_w), .snp_addr(snp_a));

  int a_txn = 0, n_txn = 0, a_wc = 0, n_wc = 0;
  bit a_seen = 0, n_seen = 0, a_swe = 0, n_swe = 0;
  logic [7:0] a_sa = 0, n_sa = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = memv(8'(i));
    end else begin
      a_gnt <= 0; a_ack <= 0; n_gnt <= 0; n_ack <= 0; r_sv <= 0;
      if (a_breq && !a_gnt) begin
        if (a_wc >= gnt_delay) begin a_gnt <= 1; a_wc <= 0; end else a_wc <= a_wc + 1;
      end
      if (n_breq && !n_gnt) begin
        if (n_wc >= gnt_delay) begin n_gnt <= 1; n_wc <= 0; end else n_wc <= n_wc + 1;
      end
      if (a_seen) begin
        a_ack <= 1;
        if (!a_swe) a_brd <= mem[a_sa];
        if (snoop_on_ack) begin r_sv <= 1; r_sa <= a_sa; end
      end
      if (n_seen) begin
        n_ack <= 1;
        if (!n_swe) n_brd <= mem[n_sa];
      end
      a_seen <= a_bov; a_swe <= a_bwr; a_sa <= a_baddr;
      n_seen <= n_bov; n_swe <= n_bwr; n_sa <= n_baddr;
      if (a_bov) begin a_txn <= a_txn + 1; if (a_bwr) mem[a_baddr] = a_bdata; end
      if (n_bov) begin n_txn <= n_txn + 1; if (n_bwr) mem[n_baddr] = n_bdata; end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic op(input bit na, input logic we, input logic [7:0] a, input logic [15:0] wd,
                    output logic [15:0] rd, output int nb, output int reqc);
    int t0, k;
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    t0 = na ? n_txn : a_txn;
    if (na) n_req = 1; else a_req = 1;
    @(negedge clk);
    a_req = 0; n_req = 0;
    reqc = 0; k = 0;
    while (!(na ? n_done : a_done) && k < 60) begin
      reqc += int'(na ? n_breq : a_breq);
      @(negedge clk);
      k++;
    end
    rd = na ? n_rd : a_rd;
    nb = (na ? n_txn : a_txn) - t0;
  endtask

  task automatic snoop(input logic w, input logic [7:0] a);
    @(negedge clk);
    tb_sv = 1; tb_sw = w; tb_sa = a;
    @(negedge clk);
    tb_sv = 0; tb_sw = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  a;
    logic [15:0] wd;
    logic [15:0] ex;
    logic [1:0]  nb;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 8'h10, 16'h0000, memv(8'h10), 2'd1},
    '{1'b0, 8'h10, 16'h0000, memv(8'h10), 2'd0},
    '{1'b1, 8'h10, 16'h1234, 16'h1234,    2'd1},
    '{1'b0, 8'h10, 16'h0000, 16'h1234,    2'd0},
    '{1'b1, 8'h21, 16'hABCD, 16'hABCD,    2'd1},
    '{1'b0, 8'h21, 16'h0000, 16'hABCD,    2'd0},
    '{1'b0, 8'h14, 16'h0000, memv(8'h14), 2'd1},
    '{1'b0, 8'h10, 16'h0000, 16'h1234,    2'd1}
  };

  initial begin
    logic [15:0] rd;
    int nb, rc;
    repeat (3) @(negedge clk);
    chk("R1 bus_req", {31'd0, a_breq}, 0);
    chk("R1 bus_out_valid", {31'd0, a_bov}, 0);
    chk("R1 cpu_done", {31'd0, a_done}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      op(0, VEC[i].we, VEC[i].a, VEC[i].wd, rd, nb, rc);
      chk($sformatf("R2/R3/R4/R5 vec%0d data", i), {16'd0, rd}, {16'd0, VEC[i].ex});
      chk($sformatf("R2/R3/R4/R5 vec%0d bus txns", i), nb, {30'd0, VEC[i].nb});
    end

    gnt_delay = 3;
    op(0, 0, 8'h33, 0, rd, nb, rc);
    chk("R9 req held until grant", rc, 4);
    chk("R9 one transaction", nb, 1);
    chk("R3 miss data with delay", {16'd0, rd}, {16'd0, memv(8'h33)});
    gnt_delay = 0;

    op(0, 0, 8'h22, 0, rd, nb, rc);
    snoop(1, 8'h22);
    op(0, 0, 8'h22, 0, rd, nb, rc);
    chk("R7 snooped write invalidates", nb, 1);

    op(0, 0, 8'h23, 0, rd, nb, rc);
    snoop(0, 8'h23);
    op(0, 0, 8'h23, 0, rd, nb, rc);
    chk("R8 snooped read no effect", nb, 0);
    snoop(1, 8'h27);
    op(0, 0, 8'h23, 0, rd, nb, rc);
    chk("R8 snooped write tag mismatch no effect", nb, 0);
    chk("R8 data kept", {16'd0, rd}, {16'd0, memv(8'h23)});

    snoop_on_ack = 1;
    op(0, 0, 8'h31, 0, rd, nb, rc);
    snoop_on_ack = 0;
    op(0, 0, 8'h31, 0, rd, nb, rc);
    chk("R10 snoop wins over install", nb, 1);

    op(1, 1, 8'h41, 16'h5555, rd, nb, rc);
    chk("R6 no-allocate write txn", nb, 1);
    op(1, 0, 8'h41, 0, rd, nb, rc);
    chk("R6 line stays invalid", nb, 1);
    chk("R6 data from memory", {16'd0, rd}, 32'h5555);
    op(1, 1, 8'h41, 16'h7777, rd, nb, rc);
    chk("R4 no-alloc write to valid txn", nb, 1);
    op(1, 0, 8'h41, 0, rd, nb, rc);
    chk("R4 no-alloc valid write updates", {16'd0, rd}, 32'h7777);
    chk("R4 no-alloc hit after write", nb, 0);

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule